// File: doc/BRIEF.md
# Windowed Spill/Fill State Tracker

This block keeps the bookkeeping of a register-window machine that counts windows in the reverse direction: the number of windows that can still be saved, the number that can be restored, the number that belong to another context, and the number that are known to be clean. It also keeps the current window index and a six-bit window-state register. A command arrives as a one-cycle strobe with a four-bit opcode and a data byte. The commands are save, restore, flush-windows, saved, restored and register writes. Results appear on the registered outputs one clock after the strobe.

When a command cannot proceed, the block leaves all of its state unchanged. It then raises a one-cycle trap request that carries a nine-bit trap type. For spill and fill traps the type is made from the window-state register. One half of that register is used when other-context windows exist, and the other half when none do. The window index is held internally counting downward on save. It is shown and written in architectural form, which is the number of windows minus one minus the internal value. The register file and the trap dispatch sit outside this block.

Top module: `win_spill_fill_tracker`

## Requirements
- R1: A save (opcode 1) while the save counter is 0 raises a trap in the next cycle and changes no counter, index or window-state value.
- R2: A restore (opcode 2) while the restore counter is 0 raises a trap and changes no state.
- R3: A spill trap has type 0x080 and a fill trap has type 0x0C0. This base is ORed with 0x020 | (wstate[5:3] << 2) when the other-context counter is nonzero, and with wstate[2:0] << 2 when it is zero.
- R4: A save that passes the check of R1 but finds the clean counter equal to the restore counter raises a clean-window trap of type 0x024 and changes no state.
- R5: A save without a trap decrements the save counter, increments the restore counter and decrements the internal index modulo NWIN. A restore without a trap does the reverse and increments the internal index modulo NWIN.
- R6: Flush-windows (opcode 3) raises a spill trap, with the type built as in R3, when the save counter differs from NWIN-2. Otherwise it raises no trap and changes nothing.
- R7: Saved (opcode 4) increments the save counter. It then decrements the other-context counter if that counter is nonzero, and otherwise decrements the restore counter.
- R8: Restored (opcode 5) increments the restore counter. It increments the clean counter only while that counter is below NWIN-1. It then decrements the other-context counter if nonzero, and otherwise decrements the save counter.
- R9: The index output equals NWIN-1 minus the internal index. A write of the index (opcode 6) first reduces the data modulo NWIN and then stores NWIN-1 minus the result internally.
- R10: After synchronous reset the save counter is NWIN-2, the clean counter is NWIN-1, the restore counter, other-context counter, internal index and window-state are 0, and no trap is raised.
- R11: Opcode 7 loads the window-state from data[5:0]. Opcodes 8, 9, 10 and 11 load the save, restore, other-context and clean counters from the low data bits. Opcode 0 and opcodes 12 to 15 change nothing. Every counter wraps modulo 2^CW.
- R12: The trap request lasts exactly one cycle, and no command is taken while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| cmd_data | input | DW | Data for the write commands |
| cansave | output | CW | Windows that can still be saved |
| canrestore | output | CW | Windows that can be restored |
| otherwin | output | CW | Windows owned by another context |
| cleanwin | output | CW | Windows known to be clean |
| arch_cwp | output | CW | Window index in architectural form |
| wstate | output | 6 | Window-state register |
| trap_valid | output | 1 | One-cycle trap request |
| trap_type | output | 9 | Trap type for the request |

## Verification
Directed cases set up each trap alone. They cover a save with no room, a save that is blocked only by the clean test, a restore with nothing to restore, and a flush with the save counter at and away from NWIN-2. Each of these is run with the other-context counter both zero and nonzero, which shows whether the two halves of the window-state are chosen correctly. Restored with the clean counter at its cap shows the clamp apart from plain counting. An index write of a value at or above NWIN shows the modulo reduction apart from plain reversal. A long random mix of all opcodes, with random data, drives the counters through wraparound and through every trap condition. A bench model checks every output after every command.

// File: rtl/win_pkg.sv
package win_pkg;

    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_SAVE      = 4'd1,
        OP_RESTORE   = 4'd2,
        OP_FLUSH     = 4'd3,
        OP_SAVED     = 4'd4,
        OP_RESTORED  = 4'd5,
        OP_WR_CWP    = 4'd6,
        OP_WR_WSTATE = 4'd7,
        OP_WR_CSAVE  = 4'd8,
        OP_WR_CREST  = 4'd9,
        OP_WR_OTHER  = 4'd10,
        OP_WR_CLEAN  = 4'd11,
        OP_RSV12     = 4'd12,
        OP_RSV13     = 4'd13,
        OP_RSV14     = 4'd14,
        OP_RSV15     = 4'd15
    } win_op_e;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_SPILL = 2'd1,
        TK_FILL  = 2'd2,
        TK_CLEAN = 2'd3
    } trap_kind_e;

    localparam int TTW = 9;
    localparam int WSW = 6;

    localparam logic [TTW-1:0] TT_SPILL_BASE = 9'h080;
    localparam logic [TTW-1:0] TT_FILL_BASE  = 9'h0C0;
    localparam logic [TTW-1:0] TT_CLEAN_WIN  = 9'h024;
    localparam logic [TTW-1:0] TT_OTHER_FLAG = 9'h020;

    typedef struct packed {
        logic           valid;
        logic [TTW-1:0] code;
    } trap_req_t;

    function automatic logic [TTW-1:0] ws_suffix(input logic other_nz,
                                                 input logic [WSW-1:0] ws);
        logic [TTW-1:0] s;
        if (other_nz)
            s = TT_OTHER_FLAG | {4'b0, ws[5:3], 2'b00};
        else
            s = {4'b0, ws[2:0], 2'b00};
        return s;
    endfunction

endpackage

// File: rtl/win_trap_code.sv
module win_trap_code
    import win_pkg::*;
(
    input  trap_kind_e           kind,
    input  logic                 other_nz,
    input  logic [WSW-1:0]       ws,
    output logic [TTW-1:0]       code
);
    logic [TTW-1:0] suffix;

    always_comb begin
        suffix = ws_suffix(other_nz, ws);
        unique case (kind)
            TK_SPILL: code = TT_SPILL_BASE | suffix;
            TK_FILL:  code = TT_FILL_BASE | suffix;
            TK_CLEAN: code = TT_CLEAN_WIN;
            default:  code = '0;
        endcase
    end

    always_comb begin
        if (kind == TK_SPILL || kind == TK_FILL)
            p_tt_base_r3: assert (code[7] == 1'b1 && code[6] == (kind == TK_FILL));
    end
endmodule

// File: rtl/win_cwp_map.sv
module win_cwp_map #(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int DW   = 8
) (
    input  logic [CW-1:0] cwp_int,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] arch_out,
    output logic [CW-1:0] wr_int
);
    localparam logic [CW-1:0] TOP = CW'(NWIN - 1);
    localparam logic [DW-1:0] NW_D = DW'(NWIN);

    logic [DW-1:0] reduced;

    always_comb begin
        reduced  = wr_data % NW_D;
        arch_out = TOP - cwp_int;
        wr_int   = TOP - reduced[CW-1:0];
    end

    always_comb begin
        p_arch_range_r9: assert (32'(arch_out) < NWIN);
    end
endmodule

// File: rtl/win_decide.sv
module win_decide
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic          cmd_valid,
    input  win_op_e       op,
    input  logic [CW-1:0] cansave,
    input  logic [CW-1:0] canrestore,
    input  logic [CW-1:0] cleanwin,
    output trap_kind_e    kind
);
    localparam logic [CW-1:0] FLUSH_OK = CW'(NWIN - 2);

    always_comb begin
        kind = TK_NONE;
        if (cmd_valid) begin
            case (op)
                OP_SAVE: begin
                    if (cansave == '0)
                        kind = TK_SPILL;
                    else if (cleanwin == canrestore)
                        kind = TK_CLEAN;
                end
                OP_RESTORE: if (canrestore == '0) kind = TK_FILL;
                OP_FLUSH:   if (cansave != FLUSH_OK) kind = TK_SPILL;
                default:    kind = TK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/win_state.sv
module win_state
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int DW   = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  win_op_e        op,
    input  logic [DW-1:0]  data,
    input  trap_kind_e     kind,
    input  logic [TTW-1:0] code,
    input  logic [CW-1:0]  wr_cwp_int,
    output logic [CW-1:0]  cansave_q,
    output logic [CW-1:0]  canrestore_q,
    output logic [CW-1:0]  otherwin_q,
    output logic [CW-1:0]  cleanwin_q,
    output logic [CW-1:0]  cwp_q,
    output logic [WSW-1:0] wstate_q,
    output trap_req_t      trap_q
);
    localparam logic [CW-1:0] TOP      = CW'(NWIN - 1);
    localparam logic [CW-1:0] FLUSH_OK = CW'(NWIN - 2);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cwp_dec, cwp_inc;

    always_comb begin
        cwp_dec = (cwp_q == '0)  ? TOP : cwp_q - ONE;
        cwp_inc = (cwp_q == TOP) ? '0  : cwp_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cansave_q    <= FLUSH_OK;
            canrestore_q <= '0;
            otherwin_q   <= '0;
            cleanwin_q   <= TOP;
            cwp_q        <= '0;
            wstate_q     <= '0;
            trap_q       <= '0;
        end else begin
            trap_q.valid <= cmd_valid && (kind != TK_NONE);
            trap_q.code  <= code;
            if (cmd_valid && kind == TK_NONE) begin
                case (op)
                    OP_SAVE: begin
                        cansave_q    <= cansave_q - ONE;
                        canrestore_q <= canrestore_q + ONE;
                        cwp_q        <= cwp_dec;
                    end
                    OP_RESTORE: begin
                        cansave_q    <= cansave_q + ONE;
                        canrestore_q <= canrestore_q - ONE;
                        cwp_q        <= cwp_inc;
                    end
                    OP_SAVED: begin
                        cansave_q <= cansave_q + ONE;
                        if (otherwin_q != '0) otherwin_q <= otherwin_q - ONE;
                        else                  canrestore_q <= canrestore_q - ONE;
                    end
                    OP_RESTORED: begin
                        canrestore_q <= canrestore_q + ONE;
                        if (cleanwin_q < TOP) cleanwin_q <= cleanwin_q + ONE;
                        if (otherwin_q != '0) otherwin_q <= otherwin_q - ONE;
                        else                  cansave_q <= cansave_q - ONE;
                    end
                    OP_WR_CWP:    cwp_q        <= wr_cwp_int;
                    OP_WR_WSTATE: wstate_q     <= data[WSW-1:0];
                    OP_WR_CSAVE:  cansave_q    <= data[CW-1:0];
                    OP_WR_CREST:  canrestore_q <= data[CW-1:0];
                    OP_WR_OTHER:  otherwin_q   <= data[CW-1:0];
                    OP_WR_CLEAN:  cleanwin_q   <= data[CW-1:0];
                    default: ;
                endcase
            end
        end
    end

    p_spill_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_SAVE && cansave_q == '0)
        |=> (trap_q.valid && cansave_q == '0 && $stable(canrestore_q) && $stable(cwp_q)));

    p_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_RESTORE && canrestore_q == '0)
        |=> (trap_q.valid && trap_q.code[7:6] == 2'b11 && $stable(cwp_q)));

    p_save_ok_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_SAVE && cansave_q != '0 && cleanwin_q != canrestore_q)
        |=> (!trap_q.valid && cansave_q == $past(cansave_q) - ONE
             && canrestore_q == $past(canrestore_q) + ONE));

    p_flush_ok_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_FLUSH && cansave_q == FLUSH_OK)
        |=> (!trap_q.valid && $stable(cansave_q)));

    p_clean_cap_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_RESTORED && cleanwin_q == TOP)
        |=> (cleanwin_q == TOP));

    p_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid) |=> (!trap_q.valid && $stable(cansave_q) && $stable(cwp_q)
                          && $stable(wstate_q)));
endmodule

// File: rtl/win_spill_fill_tracker.sv
module win_spill_fill_tracker
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int DW   = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_op,
    input  logic [DW-1:0]  cmd_data,
    output logic [CW-1:0]  cansave,
    output logic [CW-1:0]  canrestore,
    output logic [CW-1:0]  otherwin,
    output logic [CW-1:0]  cleanwin,
    output logic [CW-1:0]  arch_cwp,
    output logic [5:0]     wstate,
    output logic           trap_valid,
    output logic [8:0]     trap_type
);
    win_op_e        op;
    trap_kind_e     kind;
    logic [TTW-1:0] code;
    logic [CW-1:0]  cwp_int, wr_cwp_int;
    trap_req_t      trap_q;

    assign op = win_op_e'(cmd_op);

    win_decide #(.NWIN(NWIN), .CW(CW)) u_decide (
        .cmd_valid  (cmd_valid),
        .op         (op),
        .cansave    (cansave),
        .canrestore (canrestore),
        .cleanwin   (cleanwin),
        .kind       (kind)
    );

    win_trap_code u_code (
        .kind     (kind),
        .other_nz (otherwin != '0),
        .ws       (wstate),
        .code     (code)
    );

    win_cwp_map #(.NWIN(NWIN), .CW(CW), .DW(DW)) u_map (
        .cwp_int  (cwp_int),
        .wr_data  (cmd_data),
        .arch_out (arch_cwp),
        .wr_int   (wr_cwp_int)
    );

    win_state #(.NWIN(NWIN), .CW(CW), .DW(DW)) u_state (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .op           (op),
        .data         (cmd_data),
        .kind         (kind),
        .code         (code),
        .wr_cwp_int   (wr_cwp_int),
        .cansave_q    (cansave),
        .canrestore_q (canrestore),
        .otherwin_q   (otherwin),
        .cleanwin_q   (cleanwin),
        .cwp_q        (cwp_int),
        .wstate_q     (wstate),
        .trap_q       (trap_q)
    );

    assign trap_valid = trap_q.valid;
    assign trap_type  = trap_q.code;

    p_trap_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && !$past(cmd_valid)) |-> 1'b0);
endmodule

// File: tb/sim_win_spill_fill_tracker.sv
`timescale 1ns/1ps
module sim_win_spill_fill_tracker;
    localparam int NW = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [3:0] cmd_op;
    logic [7:0] cmd_data;
    logic [2:0] cansave, canrestore, otherwin, cleanwin, arch_cwp;
    logic [5:0] wstate;
    logic       trap_valid;
    logic [8:0] trap_type;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_cs, m_cr, m_ow, m_cw, m_cwp, m_ws;
    int e_tv, e_tt;

    always #5 clk = ~clk;

    win_spill_fill_tracker u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cansave(cansave), .canrestore(canrestore),
        .otherwin(otherwin), .cleanwin(cleanwin), .arch_cwp(arch_cwp),
        .wstate(wstate), .trap_valid(trap_valid), .trap_type(trap_type)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int suffix_of();
        if (m_ow != 0) return 32'h20 | (((m_ws >> 3) & 7) << 2);
        return (m_ws & 7) << 2;
    endfunction

    function automatic int pack_state(int tv, int tt, int cs, int cr, int ow,
                                      int cw, int ac, int ws);
        return (tv << 31) | (tt << 22) | (cs << 19) | (cr << 16) | (ow << 13)
             | (cw << 10) | (ac << 7) | ws;
    endfunction

    function automatic int dut_state();
        return pack_state(int'(trap_valid), trap_valid ? int'(trap_type) : 0,
                          cansave, canrestore, otherwin, cleanwin, arch_cwp, wstate);
    endfunction

    task automatic step(input int op, input int data);
        string tag;
        e_tv = 0; e_tt = 0;
        case (op)
            1: if (m_cs == 0) begin e_tv = 1; e_tt = 32'h80 | suffix_of(); tag = "R1"; end
               else if (m_cw == m_cr) begin e_tv = 1; e_tt = 32'h24; tag = "R4"; end
               else begin m_cs = (m_cs-1)&7; m_cr = (m_cr+1)&7; m_cwp = (m_cwp+NW-1)%NW; tag = "R5"; end
            2: if (m_cr == 0) begin e_tv = 1; e_tt = 32'hC0 | suffix_of(); tag = "R2"; end
               else begin m_cs = (m_cs+1)&7; m_cr = (m_cr-1)&7; m_cwp = (m_cwp+1)%NW; tag = "R5"; end
            3: begin tag = "R6"; if (m_cs != NW-2) begin e_tv = 1; e_tt = 32'h80 | suffix_of(); end end
            4: begin tag = "R7"; m_cs = (m_cs+1)&7;
                   if (m_ow != 0) m_ow = m_ow-1; else m_cr = (m_cr-1)&7; end
            5: begin tag = "R8"; m_cr = (m_cr+1)&7;
                   if (m_cw < NW-1) m_cw = m_cw+1;
                   if (m_ow != 0) m_ow = m_ow-1; else m_cs = (m_cs-1)&7; end
            6: begin tag = "R9"; m_cwp = NW-1-(data % NW); end
            7: begin tag = "R11"; m_ws = data & 63; end
            8: begin tag = "R11"; m_cs = data & 7; end
            9: begin tag = "R11"; m_cr = data & 7; end
            10: begin tag = "R11"; m_ow = data & 7; end
            11: begin tag = "R11"; m_cw = data & 7; end
            default: tag = "R11";
        endcase
        cmd_op = op[3:0]; cmd_data = data[7:0]; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(tag, dut_state(),
              pack_state(e_tv, e_tt, m_cs, m_cr, m_ow, m_cw, NW-1-m_cwp, m_ws));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cs = NW-2; m_cr = 0; m_ow = 0; m_cw = NW-1; m_cwp = 0; m_ws = 0;
        @(negedge clk);
        check("R10", dut_state(), pack_state(0, 0, 6, 0, 0, 7, 7, 0));

        // R1 / R3: spill with no other-context windows
        step(7, 6'b101_011); step(8, 0); step(1, 0);
        check("R3", trap_type, 9'h08C);
        // R3: spill with other-context windows
        step(10, 2); step(1, 0);
        check("R3", trap_type, 9'h0B4);
        // R2 / R3: fill
        step(9, 0); step(2, 0);
        check("R3", trap_type, 9'h0F4);
        // R4: clean-window trap
        step(10, 0); step(8, 3); step(9, 2); step(11, 2); step(1, 0);
        check("R4", trap_type, 9'h024);
        // R5: plain save then restore
        step(11, 7); step(1, 0); step(2, 0);
        // R6: flush at and away from NWIN-2
        step(8, 6); step(3, 0);
        check("R6", trap_valid, 0);
        step(8, 5); step(3, 0);
        check("R6", trap_type, 9'h08C);
        // R8: clean counter cap
        step(11, 7); step(5, 0);
        check("R8", cleanwin, 7);
        // R7 with other-context nonzero
        step(10, 1); step(4, 0);
        check("R7", otherwin, 0);
        // R9: modulo reduction
        step(6, 10);
        check("R9", arch_cwp, 2);
        step(6, 255); step(6, 0);
        // R12: idle cycles change nothing
        @(negedge clk);
        check("R12", dut_state(), pack_state(0, 0, m_cs, m_cr, m_ow, m_cw, NW-1-m_cwp, m_ws));

        for (int i = 0; i < 3000; i++) begin
            int op;
            op = int'($urandom % 16);
            if (op >= 6 && op <= 11 && ($urandom % 3) != 0) op = int'($urandom % 6);
            step(op, int'($urandom % 256));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule